// File: doc/BRIEF.md
# Partition Isolation Access Checker

This block sits on the path from the processor to memory and decides, for every access, whether it may proceed. It holds a table that gives each partition a base address and a size. The table can be written and read only while the system is still in its start-up configuration mode. Once the system leaves that mode, the table is frozen and hidden, and the block permits accesses that fall inside the single partition that is currently active.

The active partition is chosen in hardware from the execution mode and never by software. In hypervisor mode it is partition 0. When execution enters a virtual machine mode from hypervisor mode, the partition id offered on `vm_id_i` is captured, and that partition stays active until execution returns to the hypervisor. On the return, the hypervisor partition becomes active again automatically.

When the system leaves configuration mode, the block checks that the table tiles the whole address space with no overlap and no gap. If it does not, a sticky error flag is raised and every later access is refused. A refused access, or any attempt to reach the table outside configuration mode, raises a one-cycle fault pulse.

Top module: `part_guard`

## Requirements
- R1: After reset `allow_o`, `fault_o`, `config_error_o`, `cfg_rdata_o` and `fault_addr_o` are all 0.
- R2: In configuration mode (`mode_i` = 0, never left since reset), a request with `cfg_we_i`=1 writes `cfg_wdata_i` to the base (`cfg_sel_i`=0) or the size (`cfg_sel_i`=1) of entry `cfg_idx_i`. A read request returns that value on `cfg_rdata_o` in the next cycle.
- R3: In configuration mode every valid access is allowed and raises no fault.
- R4: After configuration mode has been left, table writes have no effect, table reads return 0, and either request raises `fault_o` in the next cycle.
- R5: Leaving configuration mode is one-way until reset: driving `mode_i` back to 0 neither reopens the table nor permits any access.
- R6: In hypervisor mode (`mode_i` = 1) only addresses inside partition 0 are allowed.
- R7: On a change from hypervisor mode to a VM mode (`mode_i` = 2 or 3), `vm_id_i` is captured in that cycle; later changes of `vm_id_i` while in VM mode have no effect.
- R8: On return to hypervisor mode the active partition switches back to partition 0 without any other input.
- R9: A refused valid access gives `allow_o`=0 in the same cycle, `fault_o`=1 for exactly the next cycle, and `fault_addr_o` holds its address from then on until the next refused access.
- R10: When configuration mode is left, a table in which the partitions overlap, leave a gap, have zero size or run past the top of the address space sets `config_error_o` from the next cycle until reset. While it is set, no access is allowed.
- R11: In VM mode with active partition 0 (captured id 0, or VM mode not entered from hypervisor mode) no access is allowed.
- R12: A partition spans base up to base+size-1 inclusive; address base+size is outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Execution mode: 0 configuration, 1 hypervisor, 2 VM privileged, 3 VM user |
| vm_id_i | input | 3 | Partition id of the VM being entered |
| cfg_req_i | input | 1 | Table access request |
| cfg_we_i | input | 1 | 1 write, 0 read |
| cfg_idx_i | input | 3 | Table entry index |
| cfg_sel_i | input | 1 | 0 base, 1 size |
| cfg_wdata_i | input | 32 | Table write data |
| cfg_rdata_o | output | 32 | Table read data, one cycle after the request |
| acc_valid_i | input | 1 | Memory access valid |
| acc_addr_i | input | 32 | Memory access address |
| allow_o | output | 1 | Access permitted (same cycle) |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_addr_o | output | 32 | Address of the last refused access |
| config_error_o | output | 1 | Sticky invalid-layout flag |

## Verification
The main function is tried with a legal layout of eight equal partitions, probed at the first word, the last word and the first word past each active partition, which tells an inclusive limit from an exclusive one. The same addresses are replayed across a hypervisor to VM to hypervisor round trip and with `vm_id_i` moving while inside a VM, which separates hardware-chosen activation from a live follow of the input. Two illegal layouts, one overlapping and one leaving a gap, each tell apart the overlap check from the coverage check. Configuration traffic after the mode exit shows whether the lock is real by probing an access whose outcome a leaked write would change.

// File: rtl/part_guard_pkg.sv
package part_guard_pkg;
  typedef enum logic [1:0] {
    MODE_CFG    = 2'd0,
    MODE_HYP    = 2'd1,
    MODE_VM_SUP = 2'd2,
    MODE_VM_USR = 2'd3
  } mode_e;

  localparam logic SEL_BASE = 1'b0;
  localparam logic SEL_SIZE = 1'b1;
endpackage

// File: rtl/part_table.sv
module part_table #(
  parameter int NPART = 8,
  parameter int AW    = 32,
  localparam int IDW  = $clog2(NPART)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDW-1:0]                idx_i,
  input  logic                          sel_i,
  input  logic [AW-1:0]                 wdata_i,
  output logic [NPART-1:0][AW-1:0]      base_o,
  output logic [NPART-1:0][AW-1:0]      size_o
);
  for (genvar g = 0; g < NPART; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
        size_o[g] <= '0;
      end else if (wr_en_i && idx_i == IDW'(g)) begin
        if (sel_i == part_guard_pkg::SEL_SIZE) size_o[g] <= wdata_i;
        else                                   base_o[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/part_layout_check.sv
module part_layout_check #(
  parameter int NPART = 8,
  parameter int AW    = 32,
  localparam int IDW  = $clog2(NPART),
  localparam int SW   = AW + IDW + 1
) (
  input  logic [NPART-1:0][AW-1:0] base_i,
  input  logic [NPART-1:0][AW-1:0] size_i,
  output logic                     ok_o
);
  logic [NPART-1:0][AW:0] end_w;
  logic [SW-1:0]          total;
  logic                   clash;
  logic                   bad_ent;

  always_comb begin
    total   = '0;
    bad_ent = 1'b0;
    for (int i = 0; i < NPART; i++) begin
      end_w[i] = {1'b0, base_i[i]} + {1'b0, size_i[i]};
      total    = total + SW'(size_i[i]);
      if (size_i[i] == '0 || end_w[i] > ((AW+1)'(1) << AW)) bad_ent = 1'b1;
    end
  end

  // half-open ranges [base, end) intersect when each starts before the other ends
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NPART; i++)
      for (int j = i + 1; j < NPART; j++)
        if ({1'b0, base_i[i]} < end_w[j] && {1'b0, base_i[j]} < end_w[i]) clash = 1'b1;
  end

  // no overlap and no wrap: a total of 2^AW means full coverage
  assign ok_o = !clash && !bad_ent && (total == (SW'(1) << AW));
endmodule

// File: rtl/part_window.sv
module part_window #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic [AW:0] lim;
  assign lim   = {1'b0, base_i} + {1'b0, size_i};
  assign hit_o = ({1'b0, addr_i} >= {1'b0, base_i}) && ({1'b0, addr_i} < lim);
endmodule

// File: rtl/part_guard.sv
module part_guard #(
  parameter int NPART = 8,
  parameter int AW    = 32,
  localparam int IDW  = $clog2(NPART)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     mode_i,
  input  logic [IDW-1:0] vm_id_i,
  input  logic           cfg_req_i,
  input  logic           cfg_we_i,
  input  logic [IDW-1:0] cfg_idx_i,
  input  logic           cfg_sel_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  output logic [AW-1:0]  cfg_rdata_o,
  input  logic           acc_valid_i,
  input  logic [AW-1:0]  acc_addr_i,
  output logic           allow_o,
  output logic           fault_o,
  output logic [AW-1:0]  fault_addr_o,
  output logic           config_error_o
);
  import part_guard_pkg::*;

  mode_e                     mode_in, mode_q;
  logic                      done_q, err_q, fault_q;
  logic [IDW-1:0]            act_q, act_eff;
  logic [AW-1:0]             rdata_q, fault_addr_q, rd_val;
  logic [NPART-1:0][AW-1:0]  base_w, size_w;
  logic                      layout_ok, win_hit, init_eff, is_vm, vm_entry;
  logic                      blocked_all, permit, cfg_wr;

  assign mode_in  = mode_e'(mode_i);
  assign init_eff = !done_q && mode_in == MODE_CFG;
  assign is_vm    = mode_in == MODE_VM_SUP || mode_in == MODE_VM_USR;
  assign vm_entry = is_vm && mode_q == MODE_HYP;
  assign act_eff  = (mode_in == MODE_HYP) ? '0 : (vm_entry ? vm_id_i : act_q);
  assign cfg_wr   = cfg_req_i && cfg_we_i && init_eff;
  assign rd_val   = (cfg_sel_i == SEL_SIZE) ? size_w[cfg_idx_i] : base_w[cfg_idx_i];

  part_table #(.NPART(NPART), .AW(AW)) u_tab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_wr),
    .idx_i   (cfg_idx_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base_w),
    .size_o  (size_w)
  );

  part_layout_check #(.NPART(NPART), .AW(AW)) u_chk_lay (
    .base_i (base_w),
    .size_i (size_w),
    .ok_o   (layout_ok)
  );

  part_window #(.AW(AW)) u_win (
    .base_i (base_w[act_eff]),
    .size_i (size_w[act_eff]),
    .addr_i (acc_addr_i),
    .hit_o  (win_hit)
  );

  // bad layout also blocks the exit cycle, before err_q is set
  assign blocked_all = err_q || (!done_q && !layout_ok);
  assign permit = init_eff ||
                  (!blocked_all && win_hit &&
                   (mode_in == MODE_HYP || (is_vm && act_eff != '0)));
  assign allow_o = acc_valid_i && permit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_CFG;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
      act_q        <= '0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
      rdata_q      <= '0;
    end else begin
      mode_q <= mode_in;
      if (!done_q && mode_in != MODE_CFG) begin
        done_q <= 1'b1;
        err_q  <= !layout_ok;
      end
      if (mode_in == MODE_HYP) act_q <= '0;
      else if (vm_entry)       act_q <= vm_id_i;
      fault_q <= (acc_valid_i && !permit) || (cfg_req_i && !init_eff);
      if (acc_valid_i && !permit) fault_addr_q <= acc_addr_i;
      rdata_q <= (cfg_req_i && !cfg_we_i && init_eff) ? rd_val : '0;
    end
  end

  assign cfg_rdata_o    = rdata_q;
  assign fault_o        = fault_q;
  assign fault_addr_o   = fault_addr_q;
  assign config_error_o = err_q;
endmodule

// File: rtl/part_guard_chk.sv
module part_guard_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          done_q,
  input logic          cfg_req_i,
  input logic [AW-1:0] cfg_rdata_o,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic          allow_o,
  input logic          fault_o,
  input logic [AW-1:0] fault_addr_o,
  input logic          config_error_o
);
  p_init_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && mode_i == 2'd0 && acc_valid_i) |-> allow_o);

  p_locked_cfg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && done_q) |=> (cfg_rdata_o == '0 && fault_o));

  p_one_way_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  p_allow_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> acc_valid_i);

  p_refused_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !allow_o) |=> (fault_o && fault_addr_o == $past(acc_addr_i)));

  p_err_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    config_error_o |-> !allow_o);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    config_error_o |=> config_error_o);
endmodule

bind part_guard part_guard_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .done_q         (done_q),
  .cfg_req_i      (cfg_req_i),
  .cfg_rdata_o    (cfg_rdata_o),
  .acc_valid_i    (acc_valid_i),
  .acc_addr_i     (acc_addr_i),
  .allow_o        (allow_o),
  .fault_o        (fault_o),
  .fault_addr_o   (fault_addr_o),
  .config_error_o (config_error_o)
);

// File: tb/sim_part_guard.sv
`timescale 1ns/1ps
module sim_part_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [2:0]  vm_id_i = '0;
  logic        cfg_req_i = 1'b0, cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0, acc_addr_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] cfg_rdata_o, fault_addr_o;
  logic        allow_o, fault_o, config_error_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  part_guard u0 (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = 2'd0; vm_id_i = '0; cfg_req_i = 0; acc_valid_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic cfg_write(input int idx, input logic sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = 1; cfg_idx_i = 3'(idx); cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_req_i = 0; cfg_we_i = 0;
  endtask

  task automatic cfg_read(input int idx, input logic sel, output logic [31:0] d, output logic f);
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = 0; cfg_idx_i = 3'(idx); cfg_sel_i = sel;
    @(negedge clk_i);
    cfg_req_i = 0;
    d = cfg_rdata_o; f = fault_o;
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [2:0] id);
    @(negedge clk_i);
    mode_i = m; vm_id_i = id;
    @(negedge clk_i);
  endtask

  task automatic access(input logic [31:0] a, input logic exp_allow, input string tag);
    @(negedge clk_i);
    acc_valid_i = 1; acc_addr_i = a;
    #1;
    chk(allow_o == exp_allow, tag, 32'(allow_o), 32'(exp_allow));
    @(negedge clk_i);
    acc_valid_i = 0;
    chk(fault_o == !exp_allow, {tag, " fault"}, 32'(fault_o), 32'(!exp_allow));
    if (!exp_allow) begin
      chk(fault_addr_o == a, {tag, " fault_addr R9"}, fault_addr_o, a);
      @(negedge clk_i);
      chk(fault_o == 1'b0, "R9 one-cycle pulse", 32'(fault_o), 32'h0);
    end
  endtask

  task automatic load_tiles();
    for (int i = 0; i < 8; i++) begin
      cfg_write(i, 1'b0, 32'(i) << 29);
      cfg_write(i, 1'b1, 32'h2000_0000);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!allow_o && !fault_o && !config_error_o && cfg_rdata_o == 0 && fault_addr_o == 0,
        "R1 reset state", {27'd0, allow_o, fault_o, config_error_o, 2'b0}, 32'h0);
  endtask

  task automatic t_config();
    logic [31:0] d; logic f;
    load_tiles();
    cfg_read(5, 1'b0, d, f);
    chk(d == 32'hA000_0000 && !f, "R2 read base", d, 32'hA000_0000);
    cfg_read(7, 1'b1, d, f);
    chk(d == 32'h2000_0000, "R2 read size", d, 32'h2000_0000);
    access(32'hFFFF_FFF0, 1'b1, "R3 config mode full access");
  endtask

  task automatic t_hyp_vm();
    set_mode(2'd1, 3'd0);
    chk(config_error_o == 1'b0, "R10 good layout", 32'(config_error_o), 32'h0);
    access(32'h0000_0000, 1'b1, "R6 hyp base");
    access(32'h1FFF_FFFF, 1'b1, "R12 hyp last word");
    access(32'h2000_0000, 1'b0, "R12 hyp past end");
    access(32'h6000_0010, 1'b0, "R6 hyp other partition");
    set_mode(2'd2, 3'd3);
    access(32'h6000_0000, 1'b1, "R7 vm3 base");
    access(32'h7FFF_FFFF, 1'b1, "R12 vm3 last word");
    access(32'h8000_0000, 1'b0, "R12 vm3 past end");
    access(32'h0000_1000, 1'b0, "R7 vm3 hyp area");
    set_mode(2'd3, 3'd2);
    access(32'h6000_0010, 1'b1, "R7 vm id change ignored");
    access(32'h4000_0010, 1'b0, "R7 new id not used");
    set_mode(2'd1, 3'd2);
    access(32'h6000_0010, 1'b0, "R8 back to hyp vm area");
    access(32'h0000_0100, 1'b1, "R8 back to hyp own area");
    set_mode(2'd2, 3'd0);
    access(32'h0000_0100, 1'b0, "R11 vm id 0");
  endtask

  task automatic t_lock();
    logic [31:0] d; logic f;
    set_mode(2'd1, 3'd0);
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = 1; cfg_idx_i = 3'd0; cfg_sel_i = 1'b1; cfg_wdata_i = 32'h4000_0000;
    @(negedge clk_i);
    cfg_req_i = 0; cfg_we_i = 0;
    chk(fault_o == 1'b1, "R4 locked write fault", 32'(fault_o), 32'h1);
    access(32'h2000_0000, 1'b0, "R4 locked write no effect");
    cfg_read(0, 1'b0, d, f);
    chk(d == 0 && f, "R4 locked read zero", d, 32'h0);
    set_mode(2'd0, 3'd0);
    access(32'h0000_0100, 1'b0, "R5 config not reopened access");
    cfg_read(0, 1'b1, d, f);
    chk(d == 0 && f, "R5 config not reopened read", d, 32'h0);
  endtask

  task automatic t_bad(input string tag, input int idx, input logic sel, input logic [31:0] v);
    do_reset();
    load_tiles();
    cfg_write(idx, sel, v);
    set_mode(2'd1, 3'd0);
    chk(config_error_o == 1'b1, tag, 32'(config_error_o), 32'h1);
    access(32'h0000_0000, 1'b0, {tag, " blocks access"});
    set_mode(2'd2, 3'd1);
    access(32'h2000_0000, 1'b0, {tag, " blocks vm"});
    chk(config_error_o == 1'b1, {tag, " sticky"}, 32'(config_error_o), 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_hyp_vm();
    t_lock();
    t_bad("R10 overlap", 1, 1'b0, 32'h1000_0000);
    t_bad("R10 gap", 7, 1'b1, 32'h1000_0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule